// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits at the back end of a high-speed 8-bit converter and produces one output word per sample clock. Each word is either the live converted sample or a word from a built-in test source. The sources are fixed levels, a checkerboard, a one/zero word toggle, two pseudo-random sequences, and a user pattern that steps through two programmable words and zero. Every word then passes through the same format conversion and optional bit inversion. The output is registered, and a valid strobe marks the words that follow reset.

Firmware programs the block through a small register write port. The fixed levels and the live input are treated as offset binary before conversion. Both pseudo-random generators run all the time, so a test can switch between them, or hold either one at its seed, without disturbing the other.

Top module: `adc_pattern_gen`

## Requirements
- R1: A write (wr_en high at a rising edge) loads the register at wr_addr. The register map is: 0 = {seq[5:4], mode[3:0]}; 1 = {invert[2], format[1:0]}; 2 = {pn23_hold[1], pn9_hold[0]}; 3 = P1 low byte; 4 = P1 high byte; 5 = P2 low byte; 6 = P2 high byte. Reset clears every field to zero except format, which resets to 01. While reset is asserted, dout is 0x00 and dout_valid is low. dout_valid is high from the first rising edge after reset is released.
- R2: dout is registered. The word built from the inputs and registers present at rising edge k appears on dout after edge k. Mode codes 0000 and 1001 through 1111 pass live_data.
- R3: Mode 0001 gives 0x80, mode 0010 gives 0xFF and mode 0011 gives 0x00. All three are offset-binary values before format conversion.
- R4: Mode 0100 alternates 0xAA and 0x55, starting at 0xAA. Mode 0111 alternates 0xFF and 0x00, starting at 0xFF.
- R5: Mode 1000 uses seq. 00 gives P1 on every sample. 01 gives P1, P2, P1 and so on. 10 gives P1, 0x00, P1 and so on. 11 repeats P1, P2, 0x00.
- R6: Only the high bytes (registers 4 and 6) form P1 and P2. Writes to registers 3 and 5 do not change the output.
- R7: Every write to register 0 restarts the pattern phase, so the first word after the write is the first word of the pattern (P1, 0xAA or 0xFF).
- R8: Mode 0110 outputs PN9. The polynomial is x^9+x^5+1 (new bit = s[8]^s[4], shifted into s[0]), the seed is all ones, the state advances 8 bits per clock, and the output word is s[8:1].
- R9: Mode 0101 outputs PN23. The polynomial is x^23+x^18+1 (new bit = s[22]^s[17]), the seed is all ones, the state advances 8 bits per clock, and the output word is s[22:15].
- R10: While a generator's hold bit is set, that generator stays at its seed and does not advance. After the bit is cleared, it steps forward from the seed. Each hold bit affects only its own generator.
- R11: Format 00 leaves the word as offset binary. Format 01 flips bit 7 (two's complement). Format 10 gives Gray code, w ^ (w >> 1). Format 11 behaves as 00.
- R12: When invert is set, every bit of the formatted word is complemented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| live_data | input | 8 | Converted sample, offset binary |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| dout | output | 8 | Formatted output word |
| dout_valid | output | 1 | High on every sample after reset |

## Verification
The bench rewrites register 0 in the middle of an alternation. A design that does not restart the phase would then send P2 where P1 belongs. The pseudo-random tests hold one generator while the other runs, then release it. A misplaced hold, or a generator that does not start stepping from its seed, shows up as a wrong first word or as a sequence that is offset by one step. The bench also checks the unused mode codes, which must fall back to live data; a design that decodes them wrongly would output a fixed level or zeros. Separate cases cover writes to the discarded low pattern bytes, Gray code of a live value, and inversion of the checkerboard.

// File: rtl/adc_pattern_gen.sv
`timescale 1ns/1ps
module adc_pattern_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] live_data,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] dout,
  output logic       dout_valid
);

  localparam logic [3:0] M_MID  = 4'd1;
  localparam logic [3:0] M_PFS  = 4'd2;
  localparam logic [3:0] M_NFS  = 4'd3;
  localparam logic [3:0] M_CHK  = 4'd4;
  localparam logic [3:0] M_PN23 = 4'd5;
  localparam logic [3:0] M_PN9  = 4'd6;
  localparam logic [3:0] M_TGL  = 4'd7;
  localparam logic [3:0] M_USER = 4'd8;
  localparam logic [8:0]  SEED9  = '1;
  localparam logic [22:0] SEED23 = '1;

  logic [3:0]  mode_q;
  logic [1:0]  seq_q, fmt_q, ph_q, ph_last;
  logic        inv_q, h9_q, h23_q;
  logic [7:0]  p1_q, p2_q, src, user_w, fmt_w;
  logic [8:0]  pn9_q;
  logic [22:0] pn23_q;

  wire restart = wr_en && (wr_addr == 3'd0);

  function automatic logic [8:0] pn9_adv(input logic [8:0] s);
    logic [8:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[7:0], t[8] ^ t[4]};
    return t;
  endfunction

  function automatic logic [22:0] pn23_adv(input logic [22:0] s);
    logic [22:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[21:0], t[22] ^ t[17]};
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; seq_q <= '0; fmt_q <= 2'b01; inv_q <= 1'b0;
      h9_q <= 1'b0; h23_q <= 1'b0; p1_q <= '0; p2_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: begin mode_q <= wr_data[3:0]; seq_q <= wr_data[5:4]; end
        3'd1: begin fmt_q <= wr_data[1:0]; inv_q <= wr_data[2]; end
        3'd2: begin h9_q <= wr_data[0]; h23_q <= wr_data[1]; end
        3'd4: p1_q <= wr_data;
        3'd6: p2_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign ph_last = (mode_q == M_USER && seq_q == 2'd3) ? 2'd2 : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) ph_q <= '0;
    else                   ph_q <= (ph_q >= ph_last) ? 2'd0 : ph_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || h9_q)  pn9_q  <= SEED9;  else pn9_q  <= pn9_adv(pn9_q);
    if (!rst_n || h23_q) pn23_q <= SEED23; else pn23_q <= pn23_adv(pn23_q);
  end

  always_comb begin
    case (seq_q)
      2'd0:    user_w = p1_q;
      2'd1:    user_w = ph_q[0] ? p2_q : p1_q;
      2'd2:    user_w = ph_q[0] ? 8'h00 : p1_q;
      default: user_w = (ph_q == 2'd0) ? p1_q : (ph_q == 2'd1) ? p2_q : 8'h00;
    endcase
  end

  always_comb begin
    case (mode_q)
      M_MID:   src = 8'h80;
      M_PFS:   src = 8'hFF;
      M_NFS:   src = 8'h00;
      M_CHK:   src = ph_q[0] ? 8'h55 : 8'hAA;
      M_PN23:  src = pn23_q[22:15];
      M_PN9:   src = pn9_q[8:1];
      M_TGL:   src = ph_q[0] ? 8'h00 : 8'hFF;
      M_USER:  src = user_w;
      default: src = live_data;
    endcase
  end

  always_comb begin
    case (fmt_q)
      2'd1:    fmt_w = src ^ 8'h80;
      2'd2:    fmt_w = src ^ (src >> 1);
      default: fmt_w = src;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= '0; dout_valid <= 1'b0;
    end else begin
      dout <= fmt_w ^ {8{inv_q}}; dout_valid <= 1'b1;
    end
  end

  assert_valid_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dout_valid);
  assert_live_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 4'd0 || mode_q >= 4'd9) && fmt_q == 2'd0 && !inv_q) |=> dout == $past(live_data));
  assert_midscale_twos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_MID && fmt_q == 2'd1 && !inv_q) |=> dout == 8'h00);
  assert_user_p1_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_USER && seq_q == 2'd0 && fmt_q == 2'd0 && !inv_q) |=> dout == $past(p1_q));
  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ph_q != 2'd3);
  assert_phase_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> ph_q == 2'd0);
  assert_pn9_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    h9_q |=> pn9_q == SEED9);
  assert_pn23_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    h23_q |=> pn23_q == SEED23);

endmodule

// File: tb/sim_adc_pattern_gen.sv
`timescale 1ns/1ps
module sim_adc_pattern_gen;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] live_data = 8'h00, wr_data = 8'h00;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] dout;
  logic dout_valid;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_pattern_gen u0 (.clk(clk), .rst_n(rst_n), .live_data(live_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout), .dout_valid(dout_valid));

  function automatic logic [7:0] fmt(input logic [7:0] w, input logic [1:0] f);
    if (f == 2'd1) return w ^ 8'h80;
    if (f == 2'd2) return w ^ (w >> 1);
    return w;
  endfunction

  function automatic logic [8:0] nx9(input logic [8:0] s);
    for (int i = 0; i < 8; i++) s = {s[7:0], s[8] ^ s[4]};
    return s;
  endfunction

  function automatic logic [22:0] nx23(input logic [22:0] s);
    for (int i = 0; i < 8; i++) s = {s[21:0], s[22] ^ s[17]};
    return s;
  endfunction

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) step;
    chk(dout, 8'h00, "R1 dout in reset");
    chk({7'd0, dout_valid}, 8'h00, "R1 valid low in reset");
    rst_n = 1'b1;
    step;
    chk({7'd0, dout_valid}, 8'h01, "R1 valid after reset");
    chk(dout, 8'h80, "R1 R11 default two's complement live 0x00");
  endtask

  task automatic t_live;
    logic [7:0] vals [4] = '{8'h00, 8'hFF, 8'h37, 8'hC5};
    for (int f = 0; f < 4; f++) begin
      wr(3'd1, 8'(f));
      foreach (vals[i]) begin
        live_data = vals[i];
        step;
        chk(dout, fmt(vals[i], 2'(f)), "R11 format of live data");
      end
    end
    wr(3'd1, 8'h00);
    live_data = 8'h21; step;
    live_data = 8'h9C;
    chk(dout, 8'h21, "R2 output holds until next edge");
    step;
    chk(dout, 8'h9C, "R2 one-cycle latency");
  endtask

  task automatic t_fixed;
    logic [7:0] lvl [3] = '{8'h80, 8'hFF, 8'h00};
    for (int m = 1; m <= 3; m++)
      for (int f = 0; f < 3; f++) begin
        wr(3'd1, 8'(f)); wr(3'd0, 8'(m));
        step;
        chk(dout, fmt(lvl[m-1], 2'(f)), "R3 fixed level");
      end
  endtask

  task automatic t_alt;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h04);
    for (int i = 0; i < 4; i++) begin
      step; chk(dout, i[0] ? 8'h55 : 8'hAA, "R4 checkerboard");
    end
    wr(3'd0, 8'h04);
    step; chk(dout, 8'hAA, "R7 checkerboard restarts at 0xAA");
    wr(3'd0, 8'h07);
    for (int i = 0; i < 4; i++) begin
      step; chk(dout, i[0] ? 8'h00 : 8'hFF, "R4 word toggle");
    end
  endtask

  task automatic t_user;
    logic [7:0] exp;
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h5A); wr(3'd4, 8'h12); wr(3'd5, 8'hC3); wr(3'd6, 8'h9E);
    for (int s = 0; s < 4; s++) begin
      wr(3'd0, 8'(8'h08 | (s << 4)));
      for (int i = 0; i < 6; i++) begin
        case (s)
          0: exp = 8'h12;
          1: exp = i[0] ? 8'h9E : 8'h12;
          2: exp = i[0] ? 8'h00 : 8'h12;
          default: exp = (i % 3 == 0) ? 8'h12 : (i % 3 == 1) ? 8'h9E : 8'h00;
        endcase
        step; chk(dout, exp, "R5 user sequence");
      end
    end
    wr(3'd0, 8'h18);
    step; step;
    chk(dout, 8'h9E, "R5 seq 01 second word");
    wr(3'd0, 8'h18);
    step; chk(dout, 8'h12, "R7 restart at P1 after rewrite");
    step; chk(dout, 8'h9E, "R7 then P2");
    wr(3'd0, 8'h08);
    wr(3'd3, 8'hFF); step; chk(dout, 8'h12, "R6 P1 low byte ignored");
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h18); step; step; chk(dout, 8'h9E, "R6 P2 low byte ignored");
  endtask

  task automatic t_pn9;
    logic [8:0] m;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01); wr(3'd0, 8'h06);
    step; chk(dout, 8'hFF, "R10 PN9 held at seed");
    step; chk(dout, 8'hFF, "R10 PN9 still held");
    wr(3'd2, 8'h00);
    m = '1;
    step; chk(dout, m[8:1], "R8 PN9 starts at seed");
    for (int i = 0; i < 12; i++) begin
      m = nx9(m); step; chk(dout, m[8:1], "R8 PN9 sequence");
    end
  endtask

  task automatic t_pn23;
    logic [22:0] m;
    wr(3'd2, 8'h02); wr(3'd0, 8'h05);
    step; chk(dout, 8'hFF, "R10 PN23 held at seed");
    wr(3'd2, 8'h01);
    m = '1;
    step; chk(dout, m[22:15], "R9 PN23 starts at seed");
    for (int i = 0; i < 12; i++) begin
      m = nx23(m); step; chk(dout, m[22:15], "R9 R10 PN23 runs while PN9 held");
    end
    wr(3'd0, 8'h06);
    for (int i = 0; i < 3; i++) begin
      step; chk(dout, 8'hFF, "R10 PN9 hold unaffected by PN23");
    end
    wr(3'd2, 8'h00);
  endtask

  task automatic t_unused;
    wr(3'd1, 8'h00);
    for (int c = 9; c < 16; c++) begin
      wr(3'd0, 8'(c));
      live_data = 8'(c * 23);
      step; chk(dout, 8'(c * 23), "R2 unused mode passes live");
    end
  endtask

  task automatic t_invert;
    wr(3'd1, 8'h04); wr(3'd0, 8'h04);
    step; chk(dout, 8'h55, "R12 inverted checkerboard");
    step; chk(dout, 8'hAA, "R12 inverted checkerboard");
    wr(3'd1, 8'h06); wr(3'd0, 8'h00);
    live_data = 8'h37;
    step; chk(dout, 8'hD3, "R12 R11 inverted Gray live");
  endtask

  task automatic t_reset_mid;
    wr(3'd0, 8'h04); wr(3'd1, 8'h04);
    rst_n = 1'b0;
    step;
    chk(dout, 8'h00, "R1 dout cleared by reset");
    chk({7'd0, dout_valid}, 8'h00, "R1 valid cleared by reset");
    rst_n = 1'b1; live_data = 8'h41;
    step;
    chk(dout, 8'hC1, "R1 registers back to defaults");
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_live;
    t_fixed;
    t_alt;
    t_user;
    t_pn9;
    t_pn23;
    t_unused;
    t_invert;
    t_reset_mid;
    summary;
  end
endmodule